// File: doc/BRIEF.md
# Serial Converter Configuration Sequencer

This block sits on the host side of a dual simultaneous-sampling SAR converter. It turns short commands from a local register interface into 16-bit configuration words. Each word goes to the converter over a single serial data line while a low-active read strobe frames the access. The converter samples the serial line on the falling edge of the shared clock. The sequencer therefore moves the line only just after rising edges, and the bit is stable at the sampling point.

There are three commands. A configuration write carries the power-down enables, the special read enable and the channel select. A soft reset sends one fixed word. A reference DAC write becomes two accesses that run back to back: a fixed command word first, then a data word that holds the 10-bit code. The 10-bit code sits after two don't-care leading bits.

A four-entry queue buffers commands so the host can post them ahead of time. The sequencer raises busy while any work is queued or running. It gives a one-cycle done pulse as each command completes. It accepts no new command while a DAC pair is pending.

Top module: `adc_cfg_sequencer`

## Requirements
- R1: After a synchronous active-low reset, adc_rd_n is 1, adc_sdi is 0, busy is 0, done is 0 and cmd_ready is 1.
- R2: Every access holds adc_rd_n low for exactly 16 consecutive clocks and sends its word MSB first on adc_sdi, with one bit per clock.
- R3: Opcode 0 (configuration) sends 16'h8000 OR (cmd_arg[6:0] << 4). Word bits [10:9] are the channel select. Bits 8, 7, 6, 5 and 4 are deep power-down, nap, auto-nap, reference off and special read. cmd_arg[9:7] is ignored.
- R4: Opcode 1 (soft reset) sends the single word 16'h7800, which is prefix 01 followed by address 111.
- R5: Opcode 2 (DAC write) sends 16'h4800 (prefix 01, address 001) and then cmd_arg[9:0] << 4. No other access comes between the two.
- R6: adc_rd_n stays high for at least GAP_CYC clocks (default 2) between two accesses.
- R7: Commands are sent in arrival order. Up to 4 can be queued. cmd_ready is 0 while the queue is full.
- R8: cmd_ready is 0 from the cycle after a DAC write is accepted until its second access has ended. A command offered in that time is not taken.
- R9: Opcode 3 is discarded. It produces no access and no done pulse.
- R10: done is a single-cycle pulse after the last access of each command. busy is 1 while a command is queued or being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock shared with the sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command this cycle |
| cmd_op | input | 2 | Command opcode (0 config, 1 reset, 2 DAC, 3 discarded) |
| cmd_arg | input | 10 | Command argument (config bits or DAC code) |
| cmd_ready | output | 1 | Sequencer can take a command this cycle |
| busy | output | 1 | Commands queued or in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| adc_rd_n | output | 1 | Low-active access strobe to the converter |
| adc_sdi | output | 1 | Serial configuration data, MSB first |

## Verification
A serial-to-parallel model rebuilds every frame from falling-edge samples and compares it with a word computed arithmetically. All 128 configuration argument patterns are sent, so every enable bit and channel value is seen in each position. All 1024 DAC codes are sent, which shows that the code bits land in the right slots and that the command word always comes first. Back-to-back bursts that fill the queue separate correct ordering and back-pressure from single-command behaviour. Commands offered during a DAC pair and the discarded opcode show whether stray input can add or change a frame.

// File: rtl/cfgseq_pkg.sv
// Shared types and field codes for the configuration sequencer.
// Assumes a 16-bit serial word whose leading prefix and address fields
// are decoded by the converter; their values must not move.
package cfgseq_pkg;
    localparam int WORD_W = 16;
    localparam int ARG_W  = 10;
    localparam int CFG_W  = 7;

    typedef enum logic [1:0] {
        OP_CFG = 2'd0,
        OP_RST = 2'd1,
        OP_DAC = 2'd2,
        OP_BAD = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    localparam logic [1:0] PFX_CFG = 2'b10;
    localparam logic [1:0] PFX_CMD = 2'b01;
    localparam logic [2:0] ADR_CFG = 3'b000;
    localparam logic [2:0] ADR_RST = 3'b111;
    localparam logic [2:0] ADR_DAC = 3'b001;
endpackage

// File: rtl/cmd_fifo.sv
// Command queue: holds decoded commands until the sequencer is free.
// Assumes the writer never pushes when full and the reader never pops
// when empty.
module cmd_fifo
    import cfgseq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  cmd_t din,
    input  logic pop,
    output cmd_t dout,
    output logic full,
    output logic empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    cmd_t          mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Storage write: the entry at the write pointer takes the new command.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r9_no_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (din.op != OP_BAD));
endmodule

// File: rtl/sdi_word_enc.sv
// Combinational encoder from a command (and the DAC phase) to the serial word.
// Assumes the arg field holds config bits in [6:0] or a DAC code in [9:0].
module sdi_word_enc
    import cfgseq_pkg::*;
(
    input  op_e               op,
    input  logic [ARG_W-1:0]  arg,
    input  logic              second,
    output logic [WORD_W-1:0] word
);
    // Field packing; spare low bits are always zero.
    always_comb begin
        word = '0;
        case (op)
            OP_CFG: word = {PFX_CFG, ADR_CFG, arg[CFG_W-1:0], 4'b0000};
            OP_RST: word = {PFX_CMD, ADR_RST, 11'b0};
            OP_DAC: word = second ? {2'b00, arg, 4'b0000}
                                  : {PFX_CMD, ADR_DAC, 11'b0};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/frame_shifter.sv
// Serialises one word per access: the strobe is low for WORD_W clocks and the
// data moves MSB first. Outputs come straight from registers, so they change
// just after a rising edge. Assumes start is only raised while idle.
module frame_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              rd_n,
    output logic              sdi,
    output logic              last
);
    localparam int BW = $clog2(WORD_W);

    logic              active;
    logic [BW-1:0]     bitn;
    logic [WORD_W-1:0] sh;

    // Load on start, then shift left once per clock until the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bitn   <= '0;
            sh     <= '0;
        end else if (start) begin
            active <= 1'b1;
            bitn   <= '0;
            sh     <= word;
        end else if (active) begin
            sh   <= {sh[WORD_W-2:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (bitn == BW'(WORD_W - 1)) active <= 1'b0;
        end
    end

    assign rd_n = !active;
    assign sdi  = active & sh[WORD_W-1];
    assign last = active && (bitn == BW'(WORD_W - 1));

    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
endmodule

// File: rtl/adc_cfg_sequencer.sv
// Top: accepts host commands, queues them, and turns each into one access
// (or two for a DAC write) with a guard gap between accesses. Assumes
// the converter samples adc_sdi on falling clk edges.
module adc_cfg_sequencer
    import cfgseq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ARG_W-1:0] cmd_arg,
    output logic             cmd_ready,
    output logic             busy,
    output logic             done,
    output logic             adc_rd_n,
    output logic             adc_sdi
);
    localparam int GCW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} st_e;

    st_e               st;
    cmd_t              cur, head, din;
    logic              second, dac_lock, done_q;
    logic [GCW-1:0]    gcnt;
    logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic              gap_end, need_second, frm_start, frm_last;
    op_e               enc_op;
    logic [ARG_W-1:0]  enc_arg;
    logic [WORD_W-1:0] enc_word;

    assign din         = '{op: op_e'(cmd_op), arg: cmd_arg};
    assign cmd_ready   = !fifo_full && !dac_lock;
    assign fifo_push   = cmd_valid && cmd_ready && (cmd_op != 2'(OP_BAD));
    assign fifo_pop    = (st == ST_IDLE) && !fifo_empty;
    assign gap_end     = (st == ST_GAP) && (gcnt == GCW'(GAP_CYC - 1));
    assign need_second = (cur.op == OP_DAC) && !second;
    assign frm_start   = fifo_pop || (gap_end && need_second);
    assign enc_op      = fifo_pop ? head.op  : cur.op;
    assign enc_arg     = fifo_pop ? head.arg : cur.arg;
    assign busy        = (st != ST_IDLE) || !fifo_empty;
    assign done        = done_q;

    cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(din),
        .pop(fifo_pop), .dout(head), .full(fifo_full), .empty(fifo_empty)
    );

    sdi_word_enc u_enc (
        .op(enc_op), .arg(enc_arg), .second(!fifo_pop), .word(enc_word)
    );

    frame_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(frm_start), .word(enc_word),
        .rd_n(adc_rd_n), .sdi(adc_sdi), .last(frm_last)
    );

    // Command sequencing: idle -> access -> guard gap -> next access or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cur    <= '{op: OP_CFG, arg: '0};
            second <= 1'b0;
            gcnt   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (fifo_pop) begin
                    cur    <= head;
                    second <= 1'b0;
                    st     <= ST_FRAME;
                end
                ST_FRAME: if (frm_last) begin
                    gcnt <= '0;
                    st   <= ST_GAP;
                end
                ST_GAP: begin
                    gcnt <= gcnt + 1'b1;
                    if (gap_end) begin
                        if (need_second) begin
                            second <= 1'b1;
                            st     <= ST_FRAME;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse and DAC-pair lock on command intake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            dac_lock <= 1'b0;
        end else begin
            done_q <= gap_end && !need_second;
            if (fifo_push && (cmd_op == 2'(OP_DAC)))
                dac_lock <= 1'b1;
            else if (gap_end && (cur.op == OP_DAC) && second)
                dac_lock <= 1'b0;
        end
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_dac_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && (cur.op == OP_DAC)) |-> !cmd_ready);
    a_r10_busy_running: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> busy);

    generate
        if (GAP_CYC >= 2) begin : g_gap_chk
            a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(adc_rd_n) |=> adc_rd_n);
        end
    endgenerate
endmodule

// File: tb/tb_adc_cfg_sequencer.sv
module tb_adc_cfg_sequencer;
    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [9:0] cmd_arg = '0;
    logic       cmd_ready, busy, done, adc_rd_n, adc_sdi;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int dones  = 0;
    int bitcnt = 0;
    int hirun  = 100;
    bit finished = 0;
    logic [15:0] sh = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    adc_cfg_sequencer #(.DEPTH(4), .GAP_CYC(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .busy(busy), .done(done),
        .adc_rd_n(adc_rd_n), .adc_sdi(adc_sdi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Serial-to-parallel model sampling on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) dones++;
            if (!adc_rd_n) begin
                if (bitcnt == 0 && frames > 0) chk("R6 gap", (hirun >= GAP), 1);
                hirun = 0;
                sh = {sh[14:0], adc_sdi};
                bitcnt++;
                if (bitcnt == 16) begin
                    frames++;
                    if (exp_q.size() == 0) chk("R3 unexpected frame", sh, 16'hxxxx);
                    else chk(tag_q.pop_front(), sh, exp_q.pop_front());
                end
                if (bitcnt == 17) chk("R2 frame too long", bitcnt, 16);
            end else begin
                if (bitcnt != 0) begin
                    chk("R2 frame length", bitcnt, 16);
                    bitcnt = 0;
                end
                hirun++;
            end
        end
    end

    task automatic expect_word(input string tag, input logic [15:0] w);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [1:0] op, input logic [9:0] arg);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        case (op)
            2'd0: expect_word("R3", 16'h8000 | (16'(arg[6:0]) << 4));
            2'd1: expect_word("R4", 16'h7800);
            2'd2: begin
                expect_word("R5 cmd", 16'h4800);
                expect_word("R5 data", 16'(arg) << 4);
            end
            default: ;
        endcase
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int d0;
        int f0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_n", adc_rd_n, 1);
        chk("R1 sdi", adc_sdi, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 cmd_ready", cmd_ready, 1);

        // R3: every configuration argument, with the unused upper bits set.
        d0 = dones;
        for (int a = 0; a < 128; a++) begin
            send(2'd0, 10'(a) | 10'h380);
            if (a == 5) begin
                @(negedge clk);
                chk("R10 busy", busy, 1);
            end
            wait_idle();
        end
        chk("R10 done count", dones - d0, 128);
        chk("R3 all frames seen", exp_q.size(), 0);

        // R4: soft reset word.
        send(2'd1, 10'h3FF);
        wait_idle();

        // R5/R8: every DAC code; commands offered during the pair are blocked.
        for (int c = 0; c < 1024; c++) begin
            send(2'd2, 10'(c));
            if (c % 256 == 0) begin
                @(negedge clk);
                cmd_valid = 1'b1;
                cmd_op    = 2'd0;
                cmd_arg   = 10'h7F;
                for (int k = 0; k < 5; k++) begin
                    chk("R8 ready low", cmd_ready, 0);
                    @(negedge clk);
                end
                cmd_valid = 1'b0;
            end
            wait_idle();
            if (c % 256 == 0) chk("R8 ready back", cmd_ready, 1);
        end
        chk("R5 all frames seen", exp_q.size(), 0);

        // R9: discarded opcode.
        d0 = dones;
        f0 = frames;
        send(2'd3, 10'h155);
        repeat (40) @(negedge clk);
        chk("R9 no frame", frames - f0, 0);
        chk("R9 no done", dones - d0, 0);
        chk("R9 busy", busy, 0);

        // R7: five back-to-back commands fill the queue and stay in order.
        d0 = dones;
        send(2'd0, 10'h011);
        send(2'd1, 10'h000);
        send(2'd0, 10'h022);
        send(2'd0, 10'h044);
        send(2'd0, 10'h008);
        @(negedge clk);
        chk("R7 full ready", cmd_ready, 0);
        chk("R10 busy queued", busy, 1);
        wait_idle();
        chk("R7 order drained", exp_q.size(), 0);
        chk("R10 burst dones", dones - d0, 5);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule